// File: doc/BRIEF.md
# Match and Capture Timer

A free-running counter advanced by a prescaler, with four compare lanes and one capture input. Each compare lane holds a value that is checked against the counter whenever the counter is about to advance. On equality the lane can raise a sticky interrupt flag, halt the timer, send the counter back to zero, and drive its own output pin in one of four ways. All of these are enabled independently, and any number of lanes may fire together.

The capture input is synchronised and edge-detected. On a selected rising or falling edge the block can latch the counter into a capture register, clear both counter and prescaler, or do both. Clearing on the leading edge of a pulse and latching on the trailing edge turns the capture register into a direct pulse-width reading. Configuration arrives on plain ports. Interrupt state leaves as a flag vector that is cleared by writing ones.

Top module: `tmr_match_timer`

## Requirements
- R1: After reset the counter, prescaler, capture value, match pins and all interrupt flags are zero, and the timer is not running.
- R2: A one-cycle `start` pulse sets the running state. While running, the prescaler counts from 0 up to `prescaleLimit`. On the cycle it sits at that limit, the counter advances by one and the prescaler returns to 0, so the counter advances once every `prescaleLimit`+1 cycles.
- R3: Lane i matches on an advance cycle where the counter equals its match value. If `matchIrqEn[i]` is set, `irqFlags[i]` becomes 1 and stays 1 until a cycle with `irqClear[i]`=1. A set and a clear in the same cycle leave the flag set.
- R4: A match on a lane with `matchResetEn` set loads zero into the counter instead of advancing it.
- R5: A match on a lane with `matchStopEn` set clears the running state and leaves the counter at the match value. When not running, the counter changes only through a capture clear.
- R6: A match on a lane with neither stop nor reset enabled lets the counter keep advancing.
- R7: Each lane owns a 2-bit field `pinAction[2i+1:2i]`, applied to `matchPins[i]` on a match: 00 keeps the pin, 01 drives it low, 10 drives it high, 11 toggles it.
- R8: When several lanes match in the same cycle, every lane's flag, pin, stop and reset action takes effect. Reset together with stop gives a counter of zero and a halted timer.
- R9: `capIn` passes through two synchronising flops before edge detection. An edge on the pin is acted on at the third rising clock edge after the change. With the matching capture enable set, `capValue` takes the counter value from before that edge, and `irqFlags[4]` (bit NM) is set.
- R10: With the matching clear enable set, a detected edge zeroes both counter and prescaler, whether or not the timer is running. This takes priority over any advance or match reset in that cycle.
- R11: With rising-edge clear and falling-edge capture enabled and `prescaleLimit`=0, a high pulse of W cycles on `capIn` leaves W-1 in `capValue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that sets the running state |
| prescaleLimit | input | CW | Prescaler terminal value |
| matchValue | input | NM*CW | Compare values, lane i in bits [i*CW +: CW] |
| matchIrqEn | input | NM | Per-lane interrupt enable |
| matchStopEn | input | NM | Per-lane stop on match |
| matchResetEn | input | NM | Per-lane reset on match |
| pinAction | input | 2*NM | Per-lane pin action field |
| capIn | input | 1 | Asynchronous capture input |
| capRiseCapEn | input | 1 | Capture on rising edge |
| capFallCapEn | input | 1 | Capture on falling edge |
| capRiseClrEn | input | 1 | Clear counter and prescaler on rising edge |
| capFallClrEn | input | 1 | Clear counter and prescaler on falling edge |
| irqClear | input | NM+1 | Write-one-to-clear for the flags |
| running | output | 1 | Running state |
| count | output | CW | Counter value |
| capValue | output | CW | Capture register |
| matchPins | output | NM | Match output pins |
| irqFlags | output | NM+1 | Sticky flags: lanes 0..NM-1, capture at bit NM |

## Verification
The bench builds the timer with a 12-bit counter and the full four compare lanes. The narrow counter keeps match values, pulse widths and the prescaler within a few dozen cycles, so every lane's action, simultaneous matches, and capture-clear against prescaler timing can all be reached in a short run. A behavioural model is stepped on every clock and compared against all outputs. Directed checks confirm the lane stop and reset points, pin actions, and the pulse-width reading.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Strobes from control to datapath, one set per clock
  typedef struct packed {
    logic advance;    // counter increments
    logic zeroCount;  // counter loads zero (priority over advance)
    logic capLoad;    // capture register takes counter
  } tmrStrobe_t;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'b00,
    PIN_LOW    = 2'b01,
    PIN_HIGH   = 2'b10,
    PIN_TOGGLE = 2'b11
  } pinAct_e;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CW = 32,
  parameter int NM = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] prescaleLimit,
  input  logic [NM-1:0] matchHit,
  input  logic [NM-1:0] matchIrqEn,
  input  logic [NM-1:0] matchStopEn,
  input  logic [NM-1:0] matchResetEn,
  input  logic          capIn,
  input  logic          capRiseCapEn,
  input  logic          capFallCapEn,
  input  logic          capRiseClrEn,
  input  logic          capFallClrEn,
  input  logic [NM:0]   irqClear,
  output tmrStrobe_t    strobe,
  output logic [NM-1:0] matchEvt,
  output logic          running,
  output logic [NM:0]   irqFlags
);
  localparam int SHW = SYNC_STAGES + 1;

  logic [CW-1:0]  preCnt;
  logic [SHW-1:0] capShift;
  logic           atLimit, anyStop, anyReset;
  logic           capRise, capFall, capClr;
  logic [NM:0]    flagSet;

  assign atLimit  = running && (preCnt == prescaleLimit);
  assign matchEvt = {NM{atLimit}} & matchHit;
  assign anyStop  = |(matchEvt & matchStopEn);
  assign anyReset = |(matchEvt & matchResetEn);

  assign capRise = capShift[SHW-2] & ~capShift[SHW-1];
  assign capFall = ~capShift[SHW-2] & capShift[SHW-1];
  assign capClr  = (capRise & capRiseClrEn) | (capFall & capFallClrEn);

  always_comb begin
    strobe.capLoad   = (capRise & capRiseCapEn) | (capFall & capFallCapEn);
    strobe.zeroCount = capClr | anyReset;
    strobe.advance   = atLimit & ~anyStop;
  end

  assign flagSet = {strobe.capLoad, matchEvt & matchIrqEn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      capShift <= '0;
      running  <= 1'b0;
      irqFlags <= '0;
    end else begin
      capShift <= {capShift[SHW-2:0], capIn};
      running  <= (running | start) & ~anyStop;
      irqFlags <= (irqFlags & ~irqClear) | flagSet;
      if (capClr || atLimit) preCnt <= '0;
      else if (running)      preCnt <= preCnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CW = 32,
  parameter int NM = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  tmrStrobe_t     strobe,
  input  logic [NM-1:0]  matchEvt,
  input  logic [NM*CW-1:0] matchValue,
  input  logic [2*NM-1:0]  pinAction,
  output logic [NM-1:0]  matchHit,
  output logic [CW-1:0]  count,
  output logic [CW-1:0]  capValue,
  output logic [NM-1:0]  matchPins
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      capValue <= '0;
    end else begin
      if (strobe.capLoad)        capValue <= count;
      if (strobe.zeroCount)      count <= '0;
      else if (strobe.advance)   count <= count + 1'b1;
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_lane
    pinAct_e act;
    assign act         = pinAct_e'(pinAction[2*i +: 2]);
    assign matchHit[i] = (count == matchValue[i*CW +: CW]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) matchPins[i] <= 1'b0;
      else if (matchEvt[i]) begin
        case (act)
          PIN_LOW:    matchPins[i] <= 1'b0;
          PIN_HIGH:   matchPins[i] <= 1'b1;
          PIN_TOGGLE: matchPins[i] <= ~matchPins[i];
          default:    matchPins[i] <= matchPins[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_match_timer.sv
module tmr_match_timer
  import tmr_pkg::*;
#(
  parameter int CW = 32,
  parameter int NM = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CW-1:0]    prescaleLimit,
  input  logic [NM*CW-1:0] matchValue,
  input  logic [NM-1:0]    matchIrqEn,
  input  logic [NM-1:0]    matchStopEn,
  input  logic [NM-1:0]    matchResetEn,
  input  logic [2*NM-1:0]  pinAction,
  input  logic             capIn,
  input  logic             capRiseCapEn,
  input  logic             capFallCapEn,
  input  logic             capRiseClrEn,
  input  logic             capFallClrEn,
  input  logic [NM:0]      irqClear,
  output logic             running,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    capValue,
  output logic [NM-1:0]    matchPins,
  output logic [NM:0]      irqFlags
);
  tmrStrobe_t    strobe;
  logic [NM-1:0] matchEvt;
  logic [NM-1:0] matchHit;

  tmr_ctrl #(.CW(CW), .NM(NM)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .prescaleLimit(prescaleLimit),
    .matchHit(matchHit), .matchIrqEn(matchIrqEn), .matchStopEn(matchStopEn),
    .matchResetEn(matchResetEn), .capIn(capIn),
    .capRiseCapEn(capRiseCapEn), .capFallCapEn(capFallCapEn),
    .capRiseClrEn(capRiseClrEn), .capFallClrEn(capFallClrEn),
    .irqClear(irqClear), .strobe(strobe), .matchEvt(matchEvt),
    .running(running), .irqFlags(irqFlags)
  );

  tmr_datapath #(.CW(CW), .NM(NM)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .matchEvt(matchEvt),
    .matchValue(matchValue), .pinAction(pinAction), .matchHit(matchHit),
    .count(count), .capValue(capValue), .matchPins(matchPins)
  );
endmodule

// File: rtl/tmr_match_timer_chk.sv
module tmr_match_timer_chk
  import tmr_pkg::*;
#(
  parameter int CW = 32,
  parameter int NM = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            running,
  input logic [CW-1:0]   count,
  input logic [CW-1:0]   capValue,
  input logic [NM-1:0]   matchPins,
  input logic [NM:0]     irqFlags,
  input logic [NM:0]     irqClear,
  input logic [NM-1:0]   matchStopEn,
  input logic [2*NM-1:0] pinAction,
  input logic [NM-1:0]   matchEvt,
  input tmrStrobe_t      strobe
);
  // R2: counter moves by at most one step, or returns to zero
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    running |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

  // R5: a halted timer only holds or clears
  p_stopped_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !start) |=> (count == $past(count) || count == '0));

  // R5: halting only comes from a stop-enabled lane match
  p_stop_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> |($past(matchEvt & matchStopEn)));

  // R9: capture register changes only on a capture strobe
  p_cap_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    (capValue != $past(capValue)) |-> $past(strobe.capLoad));

  for (genvar i = 0; i <= NM; i++) begin : g_flag
    // R3: flags only drop after a clear request
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irqFlags[i]) |-> $past(irqClear[i]));
  end

  for (genvar i = 0; i < NM; i++) begin : g_pin
    // R7: keep action leaves the pin alone
    p_pin_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
      (pinAction[2*i +: 2] == 2'b00) |=> $stable(matchPins[i]));
  end
endmodule

bind tmr_match_timer tmr_match_timer_chk #(.CW(CW), .NM(NM)) chk (
  .clk(clk), .rstN(rstN), .start(start), .running(running), .count(count),
  .capValue(capValue), .matchPins(matchPins), .irqFlags(irqFlags),
  .irqClear(irqClear), .matchStopEn(matchStopEn), .pinAction(pinAction),
  .matchEvt(matchEvt), .strobe(strobe)
);

// File: tb/tmr_match_timer_test.sv
`timescale 1ns/1ps
module tmr_match_timer_test;
  localparam int CW = 12;
  localparam int NM = 4;
  localparam int MASK = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] prescaleLimit = '0;
  logic [NM*CW-1:0] matchValue;
  logic [NM-1:0] matchIrqEn = '0, matchStopEn = '0, matchResetEn = '0;
  logic [2*NM-1:0] pinAction = '0;
  logic capIn = 1'b0;
  logic capRiseCapEn = 0, capFallCapEn = 0, capRiseClrEn = 0, capFallClrEn = 0;
  logic [NM:0] irqClear = '0;
  logic running;
  logic [CW-1:0] count, capValue;
  logic [NM-1:0] matchPins;
  logic [NM:0] irqFlags;

  int mval [NM];
  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < NM; i++) matchValue[i*CW +: CW] = mval[i][CW-1:0];

  tmr_match_timer #(.CW(CW), .NM(NM)) uut (
    .clk(clk), .rstN(rstN), .start(start), .prescaleLimit(prescaleLimit),
    .matchValue(matchValue), .matchIrqEn(matchIrqEn), .matchStopEn(matchStopEn),
    .matchResetEn(matchResetEn), .pinAction(pinAction), .capIn(capIn),
    .capRiseCapEn(capRiseCapEn), .capFallCapEn(capFallCapEn),
    .capRiseClrEn(capRiseClrEn), .capFallClrEn(capFallClrEn),
    .irqClear(irqClear), .running(running), .count(count),
    .capValue(capValue), .matchPins(matchPins), .irqFlags(irqFlags)
  );

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit mRun; int mPc, mTc, mCap; bit mPins [NM]; bit mFlags [NM+1];
  bit s1, s2, s3;

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mPc = 0; mTc = 0; mCap = 0; s1 = 0; s2 = 0; s3 = 0;
      for (int i = 0; i < NM; i++) mPins[i] = 0;
      for (int i = 0; i <= NM; i++) mFlags[i] = 0;
    end else begin
      bit lim, stopAny, resetAny, rise, fall, doCap, doClr;
      bit ev [NM];
      lim = mRun && (mPc == int'(prescaleLimit));
      stopAny = 0; resetAny = 0;
      for (int i = 0; i < NM; i++) begin
        ev[i] = lim && (mTc == mval[i]);
        if (ev[i] && matchStopEn[i]) stopAny = 1;
        if (ev[i] && matchResetEn[i]) resetAny = 1;
      end
      rise = s2 && !s3; fall = !s2 && s3;
      doCap = (rise && capRiseCapEn) || (fall && capFallCapEn);
      doClr = (rise && capRiseClrEn) || (fall && capFallClrEn);
      for (int i = 0; i <= NM; i++) if (irqClear[i]) mFlags[i] = 0;
      for (int i = 0; i < NM; i++) begin
        if (ev[i] && matchIrqEn[i]) mFlags[i] = 1;
        if (ev[i]) case (pinAction[2*i +: 2])
          2'b01: mPins[i] = 0;
          2'b10: mPins[i] = 1;
          2'b11: mPins[i] = !mPins[i];
          default: ;
        endcase
      end
      if (doCap) begin mFlags[NM] = 1; mCap = mTc; end
      if (doClr || resetAny) mTc = 0;
      else if (lim && !stopAny) mTc = (mTc + 1) & MASK;
      if (doClr || lim) mPc = 0;
      else if (mRun) mPc = mPc + 1;
      mRun = (mRun || start) && !stopAny;
      s3 = s2; s2 = s1; s1 = capIn;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rstN && !finished) begin
      chk("R2 count", int'(count), mTc);
      chk("R5 running", int'(running), int'(mRun));
      chk("R9 capValue", int'(capValue), mCap);
      for (int i = 0; i < NM; i++) chk("R7 matchPins", int'(matchPins[i]), int'(mPins[i]));
      for (int i = 0; i <= NM; i++) chk("R3 irqFlags", int'(irqFlags[i]), int'(mFlags[i]));
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 0; start = 0; prescaleLimit = '0; matchIrqEn = '0; matchStopEn = '0;
    matchResetEn = '0; pinAction = '0; capIn = 0; irqClear = '0;
    capRiseCapEn = 0; capFallCapEn = 0; capRiseClrEn = 0; capFallClrEn = 0;
    for (int i = 0; i < NM; i++) mval[i] = 4000;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired (all requirements)");
    summary();
  end

  initial begin
    int maxSeen;
    for (int i = 0; i < NM; i++) mval[i] = 4000;
    doReset();
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 running", int'(running), 0);
    chk("R1 flags", int'(irqFlags), 0);
    chk("R1 pins", int'(matchPins), 0);
    chk("R1 capValue", int'(capValue), 0);

    // R2 / R6 / R3: prescale 3, lane 0 interrupt only
    prescaleLimit = 3; mval[0] = 4; matchIrqEn = 4'b0001;
    pulseStart();
    repeat (40) @(negedge clk);
    chk("R6 count passed match", int'(count > 4), 1);
    chk("R3 flag set", int'(irqFlags[0]), 1);
    irqClear = 5'b00001;
    @(negedge clk) irqClear = '0;
    chk("R3 flag cleared", int'(irqFlags[0]), 0);

    // R4: lane 1 resets at 6
    doReset();
    mval[1] = 6; matchResetEn = 4'b0010; matchIrqEn = 4'b0010;
    pulseStart();
    maxSeen = 0;
    repeat (50) begin
      @(negedge clk);
      if (int'(count) > maxSeen) maxSeen = int'(count);
    end
    chk("R4 max count", maxSeen, 6);
    chk("R4 flag", int'(irqFlags[1]), 1);

    // R5: lane 0 stops at 5
    doReset();
    prescaleLimit = 1; mval[0] = 5; matchStopEn = 4'b0001;
    pulseStart();
    repeat (40) @(negedge clk);
    chk("R5 halted", int'(running), 0);
    chk("R5 held count", int'(count), 5);

    // R8: four lanes match together
    doReset();
    for (int i = 0; i < NM; i++) mval[i] = 9;
    matchStopEn = 4'b0100; matchResetEn = 4'b1000; matchIrqEn = 4'b1000;
    pinAction = 8'b00_00_11_10;
    pulseStart();
    repeat (30) @(negedge clk);
    chk("R8 halted", int'(running), 0);
    chk("R8 count zero", int'(count), 0);
    chk("R8 flag3", int'(irqFlags[3]), 1);
    chk("R8 pin0 high", int'(matchPins[0]), 1);
    chk("R8 pin1 toggled", int'(matchPins[1]), 1);

    // R7: pin actions
    doReset();
    mval[0] = 7; mval[1] = 2; mval[3] = 2; matchResetEn = 4'b0001;
    pinAction = 8'b00_00_10_11;
    pulseStart();
    repeat (30) @(negedge clk);
    chk("R7 keep pin3", int'(matchPins[3]), 0);
    chk("R7 high pin1", int'(matchPins[1]), 1);
    pinAction = 8'b00_00_01_11;
    repeat (12) @(negedge clk);
    chk("R7 low pin1", int'(matchPins[1]), 0);

    // R9 / R10 / R11: pulse width, clear on rise, capture on fall
    doReset();
    capRiseClrEn = 1; capFallCapEn = 1;
    pulseStart();
    repeat (5) @(negedge clk);
    capIn = 1;
    repeat (3) @(negedge clk);
    chk("R10 cleared count", int'(count), 0);
    repeat (17) @(negedge clk);
    capIn = 0;
    repeat (6) @(negedge clk);
    chk("R11 pulse width", int'(capValue), 19);
    chk("R9 capture flag", int'(irqFlags[NM]), 1);

    // R10 with prescaler: clear while counting slowly
    doReset();
    prescaleLimit = 3; capRiseClrEn = 1; capRiseCapEn = 1;
    pulseStart();
    repeat (30) @(negedge clk);
    capIn = 1;
    repeat (3) @(negedge clk);
    chk("R10 clear with prescaler", int'(count), 0);
    chk("R9 captured before clear", int'(capValue != 0), 1);
    repeat (10) @(negedge clk);

    summary();
  end
endmodule